// File: doc/BRIEF.md
# Multicast Destination Set Tree Allocator

This block sits where a node injects traffic into an on-chip mesh and converts a multicast request into a reusable tree identifier. A request carries its destination set as a bit vector with one bit per node. All destination sets the node has recently used are held in a small content-addressable table and compared against the request in a single cycle. When the set is already present, the index of the matching entry becomes the tree identifier, and the multicast header is issued at once.

When the set is absent, the least recently used entry of the node is overwritten with the new set. The block then emits one unicast setup packet per destination, lowest node index first, each carrying the tree identifier. The multicast header follows immediately after the last setup packet. Each node owns an equal, fixed slice of the global tree identifier space, so tree identifiers are the node's base (node number times trees per node) plus the local entry index. The request side uses a ready/valid handshake, and ready is withheld while a setup or header issue is in progress.

Top module: `mcast_tree_alloc`

## Requirements
- R1: A request whose destination set is already stored is answered with mcast_valid high in the cycle right after acceptance, carrying the tree ID of the matching entry, and no setup packet is emitted.
- R2: A request whose nonzero set is not stored overwrites one table entry with that set and emits exactly one setup packet per set bit of the destination vector (setup_node is the bit position), each carrying the new tree ID in setup_tree.
- R3: Setup packets are emitted one per cycle in consecutive cycles, the first in the cycle right after acceptance, in strictly ascending node index order.
- R4: After a miss, the multicast header (mcast_valid with the new tree ID in mcast_tree) is issued in the cycle right after the last setup packet, and never in the same cycle as a setup packet.
- R5: A tree ID equals NODE_ID times TREES plus the local entry index (0 to TREES-1), so every emitted ID lies in the node's own range.
- R6: The victim on a miss is the least recently used entry, where both hits and fills make an entry most recently used; from reset the entries are filled in ascending index order 0, 1, 2, ...
- R7: req_ready is high in every idle cycle and low from the cycle after a nonzero set is accepted up to and including the cycle in which its multicast header is issued; a request presented while ready is low is not taken.
- R8: An all-zero destination set is accepted but produces no setup packet, no header, no stall, and leaves the table and recency order unchanged.
- R9: After reset no output is valid, req_ready is high and the table is empty, so the first nonzero request misses into entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Multicast request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_dest | input | NUM_NODES | Destination set, bit i selects node i |
| setup_valid | output | 1 | A unicast setup packet is issued this cycle |
| setup_node | output | $clog2(NUM_NODES) | Destination node of the setup packet |
| setup_tree | output | $clog2(NUM_NODES*TREES) | Tree ID carried by the setup packet |
| mcast_valid | output | 1 | Multicast header issued this cycle |
| mcast_tree | output | $clog2(NUM_NODES*TREES) | Tree ID encoded in the multicast header |

## Verification
The bench drives a stream of sets that fill the table, revisit stored sets in a shuffled order and then force evictions, so a design that picked the oldest fill instead of the least recently touched entry would send setup packets with the wrong tree ID. Single-bit sets at both ends of the vector and the full set catch a setup walker that skips the top or bottom bit, repeats a bit or emits the header one cycle early or late. Zero sets are placed between stored sets; a design that stored them, stalled on them or aged the table on them would diverge on the following hits. Requests are held valid while ready is low, so a design that took a request during a setup sequence would produce extra traffic.

// File: rtl/mtree_pkg.sv
package mtree_pkg;

    localparam int DEF_NODES = 16;
    localparam int DEF_TREES = 8;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SETUP = 2'd1,
        SQ_SEND  = 2'd2
    } seq_state_e;

    function automatic int tree_base(input int node, input int trees);
        return node * trees;
    endfunction

endpackage

// File: rtl/dset_cam.sv
module dset_cam #(
    parameter int NODES = mtree_pkg::DEF_NODES,
    parameter int TREES = mtree_pkg::DEF_TREES,
    localparam int EW   = $clog2(TREES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NODES-1:0] lookup_set,
    output logic             hit,
    output logic [EW-1:0]    hit_idx,
    input  logic             wr_en,
    input  logic [EW-1:0]    wr_idx,
    input  logic [NODES-1:0] wr_set
);
    logic [NODES-1:0] sets [TREES];
    logic [TREES-1:0] used;
    logic [TREES-1:0] match;

    for (genvar e = 0; e < TREES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                sets[e] <= '0;
                used[e] <= 1'b0;
            end else if (wr_en && wr_idx == EW'(e)) begin
                sets[e] <= wr_set;
                used[e] <= 1'b1;
            end
        end
        assign match[e] = used[e] && (sets[e] == lookup_set);
    end

    always_comb begin
        hit_idx = '0;
        for (int e = 0; e < TREES; e++) begin
            if (match[e]) hit_idx = EW'(e);
        end
    end
    assign hit = |match;

    // R1: a set is never stored twice, so at most one entry can match
    assert_unique_match_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

endmodule

// File: rtl/lru_ages.sv
module lru_ages #(
    parameter int TREES = mtree_pkg::DEF_TREES,
    localparam int EW   = $clog2(TREES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch_en,
    input  logic [EW-1:0] touch_idx,
    output logic [EW-1:0] victim
);
    logic [EW-1:0] age [TREES];
    logic [EW-1:0] touched_age;

    assign touched_age = age[touch_idx];

    for (genvar e = 0; e < TREES; e++) begin : g_age
        always_ff @(posedge clk) begin
            if (rst) begin
                age[e] <= EW'(TREES - 1 - e);
            end else if (touch_en) begin
                if (touch_idx == EW'(e))
                    age[e] <= '0;
                else if (age[e] < touched_age)
                    age[e] <= age[e] + 1'b1;
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int e = 0; e < TREES; e++) begin
            if (age[e] == EW'(TREES - 1)) victim = EW'(e);
        end
    end

    // R6: the entry just touched is the most recent one and cannot be the victim
    assert_touched_not_victim_R6: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> (victim != $past(touch_idx)));

endmodule

// File: rtl/setup_seq.sv
module setup_seq
    import mtree_pkg::*;
#(
    parameter int NODES = mtree_pkg::DEF_NODES,
    parameter int TREES = mtree_pkg::DEF_TREES,
    localparam int NW   = $clog2(NODES),
    localparam int EW   = $clog2(TREES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [NODES-1:0] req_dest,
    input  logic             hit,
    input  logic [EW-1:0]    hit_idx,
    input  logic [EW-1:0]    victim,
    output logic             fill_en,
    output logic             touch_en,
    output logic [EW-1:0]    touch_idx,
    output logic             setup_valid,
    output logic [NW-1:0]    setup_node,
    output logic             mcast_valid,
    output logic [EW-1:0]    cur_entry
);
    seq_state_e       state;
    logic [NODES-1:0] pend;
    logic [NODES-1:0] pend_next;
    logic             accept;
    logic             nonzero;

    assign req_ready = (state == SQ_IDLE);
    assign accept    = req_valid && req_ready;
    assign nonzero   = |req_dest;
    assign touch_en  = accept && nonzero;
    assign fill_en   = accept && nonzero && !hit;
    assign touch_idx = hit ? hit_idx : victim;

    // lowest pending destination: scan downward so the lowest set bit wins
    always_comb begin
        setup_node = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (pend[i]) setup_node = NW'(i);
        end
    end
    assign pend_next   = pend & ~(NODES'(1) << setup_node);
    assign setup_valid = (state == SQ_SETUP);
    assign mcast_valid = (state == SQ_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            pend      <= '0;
            cur_entry <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (touch_en) begin
                        cur_entry <= touch_idx;
                        if (hit) begin
                            state <= SQ_SEND;
                        end else begin
                            pend  <= req_dest;
                            state <= SQ_SETUP;
                        end
                    end
                end
                SQ_SETUP: begin
                    pend <= pend_next;
                    if (pend_next == '0) state <= SQ_SEND;
                end
                SQ_SEND:  state <= SQ_IDLE;
                default:  state <= SQ_IDLE;
            endcase
        end
    end

    // R3: setup destinations strictly ascend inside one sequence
    assert_setup_ascending_R3: assert property (@(posedge clk) disable iff (rst)
        (setup_valid && $past(setup_valid)) |-> (setup_node > $past(setup_node)));

    // R4: the header follows directly once the setup run ends
    assert_header_after_setup_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(setup_valid) |-> mcast_valid);

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        !(setup_valid && mcast_valid));

    // R7: taking a nonzero set closes the request side next cycle
    assert_stall_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_dest != '0)) |=> !req_ready);

    // R8: an empty set produces no traffic
    assert_zero_silent_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_dest == '0)) |=> (!setup_valid && !mcast_valid));

endmodule

// File: rtl/mcast_tree_alloc.sv
module mcast_tree_alloc
    import mtree_pkg::*;
#(
    parameter int NUM_NODES = mtree_pkg::DEF_NODES,
    parameter int TREES     = mtree_pkg::DEF_TREES,
    parameter int NODE_ID   = 0,
    localparam int NW       = $clog2(NUM_NODES),
    localparam int EW       = $clog2(TREES),
    localparam int TID_W    = $clog2(NUM_NODES * TREES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [NUM_NODES-1:0] req_dest,
    output logic                 setup_valid,
    output logic [NW-1:0]        setup_node,
    output logic [TID_W-1:0]     setup_tree,
    output logic                 mcast_valid,
    output logic [TID_W-1:0]     mcast_tree
);
    localparam logic [TID_W-1:0] BASE = TID_W'(tree_base(NODE_ID, TREES));

    logic          hit;
    logic [EW-1:0] hit_idx;
    logic [EW-1:0] victim;
    logic          fill_en;
    logic          touch_en;
    logic [EW-1:0] touch_idx;
    logic [EW-1:0] cur_entry;
    logic [TID_W-1:0] tree_id;

    dset_cam #(.NODES(NUM_NODES), .TREES(TREES)) u_cam (
        .clk        (clk),
        .rst        (rst),
        .lookup_set (req_dest),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .wr_en      (fill_en),
        .wr_idx     (victim),
        .wr_set     (req_dest)
    );

    lru_ages #(.TREES(TREES)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .victim    (victim)
    );

    setup_seq #(.NODES(NUM_NODES), .TREES(TREES)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_dest    (req_dest),
        .hit         (hit),
        .hit_idx     (hit_idx),
        .victim      (victim),
        .fill_en     (fill_en),
        .touch_en    (touch_en),
        .touch_idx   (touch_idx),
        .setup_valid (setup_valid),
        .setup_node  (setup_node),
        .mcast_valid (mcast_valid),
        .cur_entry   (cur_entry)
    );

    assign tree_id    = BASE + TID_W'(cur_entry);
    assign setup_tree = tree_id;
    assign mcast_tree = tree_id;

    // R5: emitted tree IDs stay inside this node's slice
    assert_setup_range_R5: assert property (@(posedge clk) disable iff (rst)
        setup_valid |-> (setup_tree >= BASE && setup_tree < BASE + TID_W'(TREES)));

    assert_mcast_range_R5: assert property (@(posedge clk) disable iff (rst)
        mcast_valid |-> (mcast_tree >= BASE && mcast_tree < BASE + TID_W'(TREES)));

endmodule

// File: tb/test_mcast_tree_alloc.sv
module test_mcast_tree_alloc;
    localparam int N     = 16;
    localparam int T     = 8;
    localparam int NODE  = 5;
    localparam int NW    = $clog2(N);
    localparam int TID_W = $clog2(N * T);
    localparam int NSTIM = 36;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [N-1:0] req_dest = '0;
    logic setup_valid;
    logic [NW-1:0] setup_node;
    logic [TID_W-1:0] setup_tree;
    logic mcast_valid;
    logic [TID_W-1:0] mcast_tree;

    always #4 clk = ~clk;  // 125 MHz

    mcast_tree_alloc #(.NUM_NODES(N), .TREES(T), .NODE_ID(NODE)) i_mcast_tree_alloc (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_dest(req_dest), .setup_valid(setup_valid), .setup_node(setup_node),
        .setup_tree(setup_tree), .mcast_valid(mcast_valid), .mcast_tree(mcast_tree)
    );

    typedef struct {
        bit    is_mc;
        int    node;
        int    tid;
        string tag;
    } ev_t;

    ev_t      evq [$];
    int       lru [$];
    bit [N-1:0] mset [T];
    bit       mused [T];
    int       errors = 0;
    int       checks = 0;
    logic [N-1:0] stim [NSTIM];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic touch(input int e);
        foreach (lru[i]) if (lru[i] == e) begin lru.delete(i); break; end
        lru.push_back(e);
    endtask

    // reference: decide hit/miss and queue the expected output cycles
    task automatic model_accept(input logic [N-1:0] d);
        int e;
        bit full;
        ev_t ev;
        if (d == '0) return;  // R8: nothing stored, nothing emitted
        e = -1;
        for (int k = 0; k < T; k++) if (mused[k] && mset[k] == d) e = k;
        if (e >= 0) begin
            touch(e);
            ev.is_mc = 1; ev.node = 0; ev.tid = NODE * T + e; ev.tag = "R1";
            evq.push_back(ev);
        end else begin
            e = lru[0];
            full = mused[e];
            mset[e] = d; mused[e] = 1;
            touch(e);
            for (int b = 0; b < N; b++) if (d[b]) begin
                ev.is_mc = 0; ev.node = b; ev.tid = NODE * T + e;
                ev.tag = full ? "R6 setup" : "R2/R3 setup";
                evq.push_back(ev);
            end
            ev.is_mc = 1; ev.node = 0; ev.tid = NODE * T + e; ev.tag = "R4 header";
            evq.push_back(ev);
        end
    endtask

    initial begin
        int idx;
        int gap;
        int cyc;
        bit idle;
        ev_t ev;
        for (int k = 0; k < T; k++) begin lru.push_back(k); mused[k] = 0; mset[k] = '0; end
        stim = '{16'h0001, 16'h8000, 16'hFFFF, 16'h0000, 16'h0001, 16'h00F0,
                 16'h8001, 16'h0000, 16'h1234, 16'hFFFF, 16'h4002, 16'h0F0F,
                 16'h0001, 16'h2200, 16'h0000, 16'h8000, 16'h5555, 16'hA0A0,
                 16'h00F0, 16'h1234, 16'h0101, 16'h8000, 16'h0001, 16'h4002,
                 16'hFFFF, 16'h3C00, 16'h0000, 16'h0F0F, 16'h2200, 16'h5555,
                 16'hC003, 16'h00F0, 16'h8001, 16'h0001, 16'h0000, 16'h7FFE};

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(req_ready === 1'b1, "R9 ready in reset", int'(req_ready), 1);
        check(setup_valid === 1'b0 && mcast_valid === 1'b0, "R9 outputs idle in reset",
              int'(setup_valid) + int'(mcast_valid), 0);
        rst = 1'b0;

        idx = 0; gap = 0; cyc = 0;
        while (cyc < 5000 && !(idx >= NSTIM && evq.size() == 0)) begin
            @(negedge clk);
            cyc++;
            idle = (evq.size() == 0);
            if (!idle) ev = evq.pop_front();
            check(req_ready === idle, "R7 ready", int'(req_ready), int'(idle));
            if (idle) begin
                check(setup_valid === 1'b0 && mcast_valid === 1'b0, "R8/R9 idle outputs",
                      int'(setup_valid) * 2 + int'(mcast_valid), 0);
            end else if (ev.is_mc) begin
                check(mcast_valid === 1'b1 && setup_valid === 1'b0, {ev.tag, " valid"},
                      int'(mcast_valid), 1);
                check(int'(mcast_tree) == ev.tid, {ev.tag, " R5 tree"}, int'(mcast_tree), ev.tid);
            end else begin
                check(setup_valid === 1'b1 && mcast_valid === 1'b0, {ev.tag, " valid"},
                      int'(setup_valid), 1);
                check(int'(setup_node) == ev.node, {ev.tag, " node"}, int'(setup_node), ev.node);
                check(int'(setup_tree) == ev.tid, {ev.tag, " R5 tree"}, int'(setup_tree), ev.tid);
            end
            // drive this cycle's request; held while not ready to exercise R7
            if (idx < NSTIM && gap == 0) begin
                req_valid = 1'b1;
                req_dest  = stim[idx];
                if (idle) begin
                    model_accept(stim[idx]);
                    idx++;
                    if (idx % 5 == 0) gap = 1;
                end
            end else begin
                req_valid = 1'b0;
                req_dest  = '0;
                gap = 0;
            end
        end
        if (cyc >= 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 0);
        end
        repeat (2) @(negedge clk);
        check(req_ready === 1'b1 && setup_valid === 1'b0 && mcast_valid === 1'b0,
              "R7 final idle", int'(req_ready), 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule